// File: doc/BRIEF.md
# MDI/MDIX Crossover Selector

This block decides whether a copper Ethernet port maps its transmit and receive pairs straight through (MDI) or crossed (MDIX). It drives one select bit that a pair multiplexer downstream follows. Configuration inputs can force crossover directly or turn automatic selection on and off. A status input says whether the port runs at a forced speed and duplex. Two activity inputs report link-up and valid negotiation pulses on the mapping currently in use.

In automatic mode the block hunts. It stays on one mapping for a dwell period and then switches to the other, until activity shows up. While activity is present the mapping stays frozen. The dwell length comes from a seeded 11-bit LFSR. Two ports built alike but seeded differently therefore do not switch in step and cannot miss each other forever. Reset comes in asynchronously and is released through a two-stage synchronizer.

Top module: `xover_sel`

## Requirements
- R1: While reset is asserted, and for two clock edges after `rst_n` rises, the hunting mapping is MDI. The first dwell after reset lasts MIN_DWELL plus the low SPAN_W bits of the seed, in hunting cycles.
- R2: With `cfg_auto_en` low and `cfg_force_x` low, `mdix_sel` is 0 (MDI) in the same cycle and stays 0.
- R3: With `cfg_force_x` high, `mdix_sel` is 1 in the same cycle, whatever the values of `cfg_auto_en` and `forced_mode`.
- R4: With `forced_mode` high and `cfg_force_x` low, `mdix_sel` is 0 and no automatic switching happens.
- R5: The block is hunting when `cfg_auto_en` is high, `forced_mode` is low, `cfg_force_x` is low, and both `link_up` and `pulse_ok` are low. While hunting, `mdix_sel` shows the hunting mapping. That mapping inverts at the clock edge that ends its dwell. At each inversion the LFSR advances one step: shift left, with bit 10 XOR bit 8 entering bit 0. The next dwell is MIN_DWELL plus the low SPAN_W bits of the advanced LFSR value.
- R6: With automatic mode active and `link_up` or `pulse_ok` high, the mapping is held unchanged and the dwell count restarts.
- R7: When activity drops during automatic mode, a full dwell starts. Its length is MIN_DWELL plus the low SPAN_W bits of the current LFSR value, with no LFSR step.
- R8: Whenever automatic mode is not active (disabled, forced mode or force bit), the hunting mapping returns to MDI. Hunting resumes on MDI with a full dwell taken from the current LFSR value.
- R9: Every dwell observed during uninterrupted hunting lasts between MIN_DWELL and MIN_DWELL + 2^SPAN_W - 1 cycles, and the lengths vary from dwell to dwell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_auto_en | input | 1 | Automatic crossover enable (1 after a default configuration) |
| cfg_force_x | input | 1 | Force crossed (MDIX) mapping |
| forced_mode | input | 1 | Port runs at forced speed/duplex; stops automatic selection |
| link_up | input | 1 | Valid link seen on the current mapping |
| pulse_ok | input | 1 | Valid negotiation pulses seen on the current mapping |
| mdix_sel | output | 1 | Pair mapping select: 0 = MDI, 1 = MDIX |

## Verification
The force, disable and forced-mode effects reach `mdix_sel` combinationally in the same cycle as the input change. A dwell inversion appears right after the edge that closes its last hunting cycle, and a reset release takes two edges to reach the state registers. The bench changes inputs on the falling edge and compares against its reference model one time unit later. By then the combinational paths have settled, and the state has already absorbed the preceding rising edge. Dwell lengths are measured at the output by counting hunting cycles between inversions, so the bounds are checked at the ports.

// File: rtl/xover_pkg.sv
package xover_pkg;

  typedef enum logic [1:0] {
    XS_IDLE_MDI = 2'd0,
    XS_FORCED   = 2'd1,
    XS_HUNT     = 2'd2,
    XS_HOLD     = 2'd3
  } xs_mode_e;

  function automatic xs_mode_e decode_mode(input logic force_x,
                                           input logic auto_en,
                                           input logic forced_mode,
                                           input logic activity);
    if (force_x)                       return XS_FORCED;
    else if (!auto_en || forced_mode)  return XS_IDLE_MDI;
    else if (activity)                 return XS_HOLD;
    else                               return XS_HUNT;
  endfunction

endpackage

// File: rtl/xover_rst_sync.sv
module xover_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/xover_lfsr.sv
module xover_lfsr #(
  parameter int          W      = 11,
  parameter int          TAP_HI = 10,
  parameter int          TAP_LO = 8,
  parameter logic [W-1:0] START = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);

  logic [W-1:0] q_q, q_d;

  assign nxt = {q_q[W-2:0], q_q[TAP_HI] ^ q_q[TAP_LO]};

  always_comb begin
    q_d = q_q;
    if (step) q_d = nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= START;
    else        q_q <= q_d;
  end

  assign q = q_q;

endmodule

// File: rtl/xover_dwell.sv
module xover_dwell #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/xover_sel.sv
module xover_sel
  import xover_pkg::*;
#(
  parameter int               LFSR_W    = 11,
  parameter int               TAP_HI    = 10,
  parameter int               TAP_LO    = 8,
  parameter logic [LFSR_W-1:0] SEED     = 11'h2B5,
  parameter int               MIN_DWELL = 64,
  parameter int               SPAN_W    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_auto_en,
  input  logic cfg_force_x,
  input  logic forced_mode,
  input  logic link_up,
  input  logic pulse_ok,
  output logic mdix_sel
);

  localparam int MAX_DWELL = MIN_DWELL + (1 << SPAN_W) - 1;
  localparam int CNT_W     = $clog2(MAX_DWELL + 1);
  localparam logic [LFSR_W-1:0] START_V = (SEED == '0) ? LFSR_W'(1) : SEED;
  localparam logic [CNT_W-1:0]  MIN_C   = CNT_W'(MIN_DWELL);
  localparam logic [CNT_W-1:0]  RST_CNT =
    CNT_W'(MIN_DWELL + int'(START_V[SPAN_W-1:0]) - 1);

  logic              rst_q_n;
  xs_mode_e          mode;
  logic [LFSR_W-1:0] lfsr_q, lfsr_nx;
  logic [CNT_W-1:0]  dwell_now, dwell_adv, load_val;
  logic              expired, load, step;
  logic              sel_q, sel_d;

  xover_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  assign mode = decode_mode(cfg_force_x, cfg_auto_en, forced_mode,
                            link_up | pulse_ok);

  // Dwell lengths taken from the current and the advanced LFSR value
  assign dwell_now = MIN_C + CNT_W'(lfsr_q[SPAN_W-1:0]);
  assign dwell_adv = MIN_C + CNT_W'(lfsr_nx[SPAN_W-1:0]);

  assign step     = (mode == XS_HUNT) && expired;
  assign load     = (mode != XS_HUNT) || expired;
  assign load_val = ((mode == XS_HUNT) ? dwell_adv : dwell_now) - CNT_W'(1);

  xover_lfsr #(
    .W      (LFSR_W),
    .TAP_HI (TAP_HI),
    .TAP_LO (TAP_LO),
    .START  (START_V)
  ) i_lfsr (
    .clk   (clk),
    .rst_n (rst_q_n),
    .step  (step),
    .q     (lfsr_q),
    .nxt   (lfsr_nx)
  );

  xover_dwell #(
    .W       (CNT_W),
    .RST_VAL (RST_CNT)
  ) i_dwell (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  always_comb begin
    case (mode)
      XS_HUNT: sel_d = sel_q ^ expired;
      XS_HOLD: sel_d = sel_q;
      default: sel_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) sel_q <= 1'b0;
    else          sel_q <= sel_d;
  end

  always_comb begin
    case (mode)
      XS_FORCED:        mdix_sel = 1'b1;
      XS_HUNT, XS_HOLD: mdix_sel = sel_q;
      default:          mdix_sel = 1'b0;
    endcase
  end

endmodule

// File: rtl/xover_sel_chk.sv
module xover_sel_chk #(
  parameter int MIN_DWELL = 1,
  parameter int MAX_DWELL = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_auto_en,
  input logic cfg_force_x,
  input logic forced_mode,
  input logic link_up,
  input logic pulse_ok,
  input logic mdix_sel
);

  logic        run, hunt;
  logic        run_q, hold_q, hunt_q, out_q;
  int unsigned seg_q;

  assign run  = cfg_auto_en && !forced_mode && !cfg_force_x;
  assign hunt = run && !(link_up || pulse_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      hold_q <= 1'b0;
      hunt_q <= 1'b0;
      out_q  <= 1'b0;
      seg_q  <= 0;
    end else begin
      run_q  <= run;
      hold_q <= run && (link_up || pulse_ok);
      hunt_q <= hunt;
      out_q  <= mdix_sel;
      if (!hunt)                              seg_q <= 0;
      else if (hunt_q && mdix_sel != out_q)   seg_q <= 1;
      else                                    seg_q <= seg_q + 1;
    end
  end

  AST_IDLE_IS_MDI: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_auto_en && !cfg_force_x) |-> !mdix_sel); // R2
  AST_FORCE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_force_x |-> mdix_sel); // R3
  AST_FORCED_MODE_MDI: assert property (@(posedge clk) disable iff (!rst_n)
    (forced_mode && !cfg_force_x) |-> !mdix_sel); // R4
  AST_HOLD_ON_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && run) |-> (mdix_sel == out_q)); // R6
  AST_RESTART_MDI: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !run_q) |-> !mdix_sel); // R8
  AST_DWELL_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (hunt && hunt_q && mdix_sel != out_q) |-> (seg_q >= MIN_DWELL)); // R9
  AST_DWELL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    seg_q <= MAX_DWELL); // R9

endmodule

bind xover_sel xover_sel_chk #(
  .MIN_DWELL (MIN_DWELL),
  .MAX_DWELL (MAX_DWELL)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .cfg_auto_en (cfg_auto_en),
  .cfg_force_x (cfg_force_x),
  .forced_mode (forced_mode),
  .link_up     (link_up),
  .pulse_ok    (pulse_ok),
  .mdix_sel    (mdix_sel)
);

// File: tb/test_xover_sel.sv
module test_xover_sel;

  localparam int CLK_P   = 10;
  localparam int MIN_D   = 8;
  localparam int SPAN    = 3;
  localparam int SEED_V  = 'h5A3;
  localparam int MAX_D   = MIN_D + (1 << SPAN) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_auto_en = 1'b1;
  logic cfg_force_x = 1'b0;
  logic forced_mode = 1'b0;
  logic link_up = 1'b0;
  logic pulse_ok = 1'b0;
  logic mdix_sel;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  int m_lfsr, m_cnt;
  bit m_sel = 1'b0;
  bit m_s0 = 1'b0, m_s1 = 1'b0;
  bit r1_win = 1'b1, r7_win = 1'b0, r8_win = 1'b0;

  // output-side dwell measurement
  bit p_hunt = 1'b0, p_out = 1'b0;
  int seg = 0;
  int first_len = -1;
  bit varied = 1'b0;

  xover_sel #(
    .LFSR_W    (11),
    .SEED      (11'(SEED_V)),
    .MIN_DWELL (MIN_D),
    .SPAN_W    (SPAN)
  ) i_xover_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_auto_en (cfg_auto_en),
    .cfg_force_x (cfg_force_x),
    .forced_mode (forced_mode),
    .link_up     (link_up),
    .pulse_ok    (pulse_ok),
    .mdix_sel    (mdix_sel)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int dwell_of(int v);
    return MIN_D + (v & ((1 << SPAN) - 1));
  endfunction

  function automatic int lfsr_step(int v);
    return ((v << 1) & 'h7FF) | (((v >> 10) ^ (v >> 8)) & 1);
  endfunction

  task automatic model_reset();
    m_lfsr = SEED_V;
    m_cnt  = dwell_of(SEED_V) - 1;
    m_sel  = 1'b0;
    r1_win = 1'b1; r7_win = 1'b0; r8_win = 1'b0;
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    bit run, act;
    run = cfg_auto_en && !forced_mode && !cfg_force_x;
    act = link_up || pulse_ok;
    if (!rst_n) begin
      m_s0 = 1'b0; m_s1 = 1'b0;
      model_reset();
    end else begin
      if (!m_s1) model_reset();
      else if (!run) begin
        m_sel = 1'b0; m_cnt = dwell_of(m_lfsr) - 1;
        r8_win = 1'b1; r1_win = 1'b0; r7_win = 1'b0;
      end else if (act) begin
        m_cnt = dwell_of(m_lfsr) - 1;
        r7_win = 1'b1; r8_win = 1'b0; r1_win = 1'b0;
      end else if (m_cnt == 0) begin
        m_sel = !m_sel; m_lfsr = lfsr_step(m_lfsr); m_cnt = dwell_of(m_lfsr) - 1;
        r1_win = 1'b0; r7_win = 1'b0; r8_win = 1'b0;
      end else m_cnt = m_cnt - 1;
      m_s1 = m_s0; m_s0 = 1'b1;
    end
  end

  task automatic check(string req, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: mdix_sel=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // compare shortly after each falling edge, once inputs have settled
  always @(negedge clk) begin
    bit run, hunt, sel_eff, exp;
    string lbl;
    #1;
    run  = cfg_auto_en && !forced_mode && !cfg_force_x;
    hunt = run && !(link_up || pulse_ok) && rst_n && m_s1;
    sel_eff = (rst_n && m_s1) ? m_sel : 1'b0;
    exp = cfg_force_x || (cfg_auto_en && !forced_mode && sel_eff);
    if (!rst_n || !m_s1)          lbl = "R1";
    else if (cfg_force_x)         lbl = "R3";
    else if (!cfg_auto_en)        lbl = "R2";
    else if (forced_mode)         lbl = "R4";
    else if (link_up || pulse_ok) lbl = "R6";
    else if (r7_win)              lbl = "R7";
    else if (r8_win)              lbl = "R8";
    else if (r1_win)              lbl = "R1";
    else                          lbl = "R5";
    check(lbl, mdix_sel, exp);
    // R9: dwell bounds measured at the output
    if (hunt && p_hunt && mdix_sel != p_out) begin
      n_chk++;
      if (seg < MIN_D || seg > MAX_D) begin
        n_fail++;
        $display("FAIL R9: dwell=%0d expected %0d..%0d", seg, MIN_D, MAX_D);
      end
      if (first_len < 0) first_len = seg;
      else if (seg != first_len) varied = 1'b1;
      seg = 1;
    end else if (hunt) seg = seg + 1;
    else seg = 0;
    p_hunt = hunt;
    p_out  = mdix_sel;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finish_run();
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;                    // R1 release and first dwell
    cyc(200);                        // R5 / R9 hunting
    link_up = 1'b1;  cyc(30);        // R6
    link_up = 1'b0;  cyc(60);        // R7
    pulse_ok = 1'b1; cyc(20);        // R6
    pulse_ok = 1'b0; cyc(40);        // R7
    cfg_force_x = 1'b1; cyc(10);     // R3 with auto on
    cfg_force_x = 1'b0; cyc(50);     // R8
    cfg_auto_en = 1'b0; cyc(40);     // R2
    cfg_force_x = 1'b1; cyc(10);     // R3 with auto off
    cfg_force_x = 1'b0; cfg_auto_en = 1'b1; cyc(50); // R8
    forced_mode = 1'b1; cyc(30);     // R4
    cfg_force_x = 1'b1; cyc(10);     // R3 in forced mode
    cfg_force_x = 1'b0; forced_mode = 1'b0; cyc(60); // R8
    rst_n = 1'b0; cyc(3);            // R1 mid-run reset
    rst_n = 1'b1; cyc(60);
    n_chk++;
    if (!varied) begin
      n_fail++;
      $display("FAIL R9: dwell lengths varied=0 expected 1");
    end
    finish_run();
  end

endmodule